// File: doc/BRIEF.md
# Serial Subcarrier Update Stream Receiver

This block listens to a one-wire control stream sent by an external video decoder and recovers from it a fresh subcarrier phase increment once per video line. Each frame on the wire is a fixed-length burst of 67 bit slots, every slot two pixel clocks wide, introduced by a low-to-high edge on a line that idles low. Only the first 22 data bits of the frame carry the increment; the remaining bits are skipped.

When a whole frame has arrived with the mode enabled, the block loads the extracted increment into its output register and raises a one-cycle update strobe. A downstream subcarrier synthesizer uses that strobe to switch to the corrected frequency line by line. The synthesizer's own programmed frequency is expected to be held at zero while this mode is active. If the mode enable is withdrawn part way through a frame, that frame is thrown away and a sticky framing-error flag is raised. The flag clears on the next frame that completes.

Top module: `subcar_stream_rx`

## Requirements
- R1: While reset is applied, and until the first complete frame, incr_o reads 0, upd_stb_o reads 0 and frame_err_o reads 0.
- R2: With mode_en high and no frame in progress, a frame begins at the first rising clock edge that sees ser_in high after an edge that saw it low. The start slot lasts two cycles and is followed by data bit 0, then bit 1 and so on, least significant bit first.
- R3: Every data bit lasts two clock cycles and is taken from the line only on the second of those cycles. The value on the first cycle has no effect.
- R4: After a complete frame, incr_o[21:0] equals frame data bits 0 to 21, with bit 0 in incr_o[0]. Data bits 22 to 66 do not affect incr_o.
- R5: upd_stb_o is high for exactly one cycle per complete frame. It rises with the clock edge that samples data bit 66, which is 135 edges after the start edge. The new incr_o value appears at that same edge.
- R6: incr_o changes only together with upd_stb_o. It keeps its value across idle time, across discarded frames and while the mode is off.
- R7: If mode_en is low at any edge during a frame, the frame is discarded and no strobe is given for it. frame_err_o goes high at that edge and stays high until the strobe of the next complete frame, which clears it.
- R8: While mode_en is low, edges on ser_in start no frame.
- R9: Level changes on ser_in inside a frame do not restart it. After a frame ends with the line high, no new frame starts until the line has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_in | input | 1 | Serial update stream, idle low |
| mode_en | input | 1 | Enables reception of the stream |
| incr_o | output | 22 | Latest subcarrier increment |
| upd_stb_o | output | 1 | One-cycle pulse when incr_o is updated |
| frame_err_o | output | 1 | Sticky flag: the last frame was cut off by mode_en falling |

## Verification
The hardest case to reach from the ports is a data bit whose first cycle differs from its second. A sampler that is off by one cycle would still decode clean, held-level frames correctly. The random frames therefore invert the line on the first cycle of every bit, so only the second-cycle sample can give the expected increment. A frame cut off by mode_en also has to be followed at once by a clean frame, to show that both the flag and the data path recover. A line left high after a frame must be shown not to start a false frame.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/ssr_rst_sync.sv
module ssr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ssr_bit_timer.sv
// Tracks the cycle inside a bit slot and the slot index inside a frame.
// Slot 0 is the start slot; slot k (k >= 1) carries data bit k-1.
module ssr_bit_timer #(
  parameter int CYC_PER_BIT = 2,
  parameter int FRAME_BITS  = 67,
  localparam int CW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1,
  localparam int SW = $clog2(FRAME_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          busy_i,
  output logic          sample_o,
  output logic          last_o,
  output logic [SW-1:0] data_idx_o
);
  localparam logic [CW-1:0] CYC_LAST  = CW'(CYC_PER_BIT - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(FRAME_BITS);

  logic [CW-1:0] cyc_q, cyc_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          slot_end;

  assign slot_end = busy_i && (cyc_q == CYC_LAST);

  always_comb begin
    cyc_d  = cyc_q;
    slot_d = slot_q;
    if (start_i) begin
      // the start edge itself is the first cycle of the start slot
      cyc_d  = CW'(1);
      slot_d = '0;
    end else if (busy_i) begin
      if (slot_end) begin
        cyc_d  = '0;
        slot_d = slot_q + SW'(1);
      end else begin
        cyc_d  = cyc_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      slot_q <= slot_d;
    end
  end

  assign sample_o   = slot_end && (slot_q != '0);
  assign last_o     = slot_end && (slot_q == SLOT_LAST);
  assign data_idx_o = slot_q - SW'(1);
endmodule

// File: rtl/ssr_field_capture.sv
// Shifts in the data bits that fall inside the increment field, LSB first.
module ssr_field_capture #(
  parameter int FIELD_LSB = 0,
  parameter int FIELD_W   = 22,
  parameter int IW        = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_i,
  input  logic [IW-1:0]      idx_i,
  input  logic               bit_i,
  output logic [FIELD_W-1:0] field_next_o
);
  localparam logic [IW-1:0] IDX_LO = IW'(FIELD_LSB);
  localparam logic [IW-1:0] IDX_HI = IW'(FIELD_LSB + FIELD_W - 1);

  logic [FIELD_W-1:0] sh_q, sh_d;
  logic               in_field;

  assign in_field = sample_i && (idx_i >= IDX_LO) && (idx_i <= IDX_HI);

  generate
    if (FIELD_W == 1) begin : g_single
      always_comb sh_d = in_field ? bit_i : sh_q;
    end else begin : g_shift
      always_comb sh_d = in_field ? {bit_i, sh_q[FIELD_W-1:1]} : sh_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign field_next_o = sh_d;
endmodule

// File: rtl/subcar_stream_rx.sv
module subcar_stream_rx #(
  parameter int FRAME_BITS  = 67,
  parameter int CYC_PER_BIT = 2,
  parameter int FIELD_LSB   = 0,
  parameter int FIELD_W     = 22,
  localparam int IW = $clog2(FRAME_BITS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_in,
  input  logic               mode_en,
  output logic [FIELD_W-1:0] incr_o,
  output logic               upd_stb_o,
  output logic               frame_err_o
);
  import ssr_pkg::*;

  logic               rst_n_i;
  rx_state_e          state_q, state_d;
  logic               ser_prev_q;
  logic [FIELD_W-1:0] incr_q, incr_d;
  logic               stb_q, stb_d;
  logic               err_q, err_d;
  logic               start, abort, done, busy;
  logic               t_sample, t_last;
  logic [IW-1:0]      t_idx;
  logic [FIELD_W-1:0] field_next;

  ssr_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  ssr_bit_timer #(
    .CYC_PER_BIT (CYC_PER_BIT),
    .FRAME_BITS  (FRAME_BITS)
  ) i_bit_timer (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .start_i    (start),
    .busy_i     (busy),
    .sample_o   (t_sample),
    .last_o     (t_last),
    .data_idx_o (t_idx)
  );

  ssr_field_capture #(
    .FIELD_LSB (FIELD_LSB),
    .FIELD_W   (FIELD_W),
    .IW        (IW)
  ) i_field_capture (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .sample_i     (t_sample),
    .idx_i        (t_idx),
    .bit_i        (ser_in),
    .field_next_o (field_next)
  );

  assign busy  = (state_q == RX_BUSY);
  assign start = (state_q == RX_IDLE) && mode_en && ser_in && !ser_prev_q;
  assign abort = busy && !mode_en;
  assign done  = busy && mode_en && t_last;

  always_comb begin
    state_d = state_q;
    incr_d  = incr_q;
    err_d   = err_q;
    stb_d   = done;
    case (state_q)
      RX_IDLE: if (start) state_d = RX_BUSY;
      RX_BUSY: if (abort || done) state_d = RX_IDLE;
      default: state_d = RX_IDLE;
    endcase
    if (done)  incr_d = field_next;
    if (abort) err_d  = 1'b1;
    else if (done) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q    <= RX_IDLE;
      ser_prev_q <= 1'b1;
      incr_q     <= '0;
      stb_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      ser_prev_q <= ser_in;
      incr_q     <= incr_d;
      stb_q      <= stb_d;
      err_q      <= err_d;
    end
  end

  assign incr_o      = incr_q;
  assign upd_stb_o   = stb_q;
  assign frame_err_o = err_q;
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int FRAME_BITS  = 67,
  parameter int CYC_PER_BIT = 2,
  parameter int FIELD_W     = 22
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_en,
  input logic [FIELD_W-1:0] incr,
  input logic               upd_stb,
  input logic               frame_err
);
  localparam int GAP_MIN = FRAME_BITS * CYC_PER_BIT;

  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= '0;
    else if (upd_stb)          gap_q <= '0;
    else if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
  end

  assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  assert_stb_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> (int'(gap_q) >= GAP_MIN));

  assert_incr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> (incr == $past(incr)));

  assert_err_rise_nostb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> !upd_stb);

  assert_err_clear_on_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_err) |-> upd_stb);

  assert_stb_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> $past(mode_en));
endmodule

bind subcar_stream_rx ssr_checker #(
  .FRAME_BITS  (FRAME_BITS),
  .CYC_PER_BIT (CYC_PER_BIT),
  .FIELD_W     (FIELD_W)
) i_ssr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_en   (mode_en),
  .incr      (incr_o),
  .upd_stb   (upd_stb_o),
  .frame_err (frame_err_o)
);

// File: tb/test_subcar_stream_rx.sv
`timescale 1ns/1ps
module test_subcar_stream_rx;
  logic        clk;
  logic        rst_n;
  logic        ser_in;
  logic        mode_en;
  logic [21:0] incr_o;
  logic        upd_stb_o;
  logic        frame_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  int early  = 0;

  subcar_stream_rx i_subcar_stream_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_in      (ser_in),
    .mode_en     (mode_en),
    .incr_o      (incr_o),
    .upd_stb_o   (upd_stb_o),
    .frame_err_o (frame_err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected increment: frame data bits 0..21, bit 0 as LSB
  function automatic logic [21:0] exp_incr(input logic [66:0] fr);
    logic [21:0] v;
    for (int i = 0; i < 22; i++) v[i] = fr[i];
    return v;
  endfunction

  function automatic logic [66:0] rand_frame();
    logic [95:0] t;
    t = {$urandom, $urandom, $urandom};
    return t[66:0];
  endfunction

  task automatic drive(input logic v);
    @(negedge clk);
    if (upd_stb_o) early++;
    ser_in = v;
  endtask

  task automatic send_frame(input logic [66:0] fr, input bit glitch,
                            input bit expect_ok, input bit hold_hi,
                            input string req);
    logic [21:0] prev;
    logic        got;
    prev  = incr_o;
    early = 0;
    drive(1'b1);
    drive(1'b1);
    for (int i = 0; i < 67; i++) begin
      drive(glitch ? ~fr[i] : fr[i]);
      drive(fr[i]);
    end
    @(negedge clk);
    got    = upd_stb_o;
    ser_in = hold_hi;
    if (expect_ok) begin
      chk(got == 1'b1 && early == 0, "R5", "strobe after bit 66", {63'd0, got}, 64'd1);
      chk(incr_o == exp_incr(fr), req, "increment R4", {42'd0, incr_o}, {42'd0, exp_incr(fr)});
      @(negedge clk);
      chk(upd_stb_o == 1'b0, "R5", "strobe one cycle", {63'd0, upd_stb_o}, 64'd0);
    end else begin
      chk(got == 1'b0 && early == 0, req, "no strobe", {63'd0, got}, 64'd0);
      chk(incr_o == prev, "R6", "increment held", {42'd0, incr_o}, {42'd0, prev});
    end
  endtask

  initial begin
    logic [66:0] fr;
    logic [21:0] held;
    int unsigned sd;
    sd      = $urandom(32'd7315);
    rst_n   = 1'b0;
    ser_in  = 1'b0;
    mode_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(incr_o == 22'd0 && upd_stb_o == 1'b0 && frame_err_o == 1'b0, "R1",
        "reset state", {41'd0, incr_o, upd_stb_o, frame_err_o}, 64'd0);
    rst_n = 1'b1;
    repeat (5) drive(1'b0);
    chk(incr_o == 22'd0 && upd_stb_o == 1'b0 && frame_err_o == 1'b0, "R1",
        "after release", {41'd0, incr_o, upd_stb_o, frame_err_o}, 64'd0);

    // directed: full field ones, rest zero; then field zero, rest ones
    fr = {45'd0, 22'h3FFFFF};
    send_frame(fr, 1'b0, 1'b1, 1'b0, "R2");
    drive(1'b0);
    fr = {45'h1FFF_FFFF_FFFF, 22'h000000};
    send_frame(fr, 1'b0, 1'b1, 1'b0, "R4");
    drive(1'b0);
    fr = {45'd0, 22'h000001};
    send_frame(fr, 1'b0, 1'b1, 1'b0, "R2");

    // random frames, first cycle of every bit inverted
    for (int n = 0; n < 20; n++) begin
      repeat (1 + ($urandom % 5)) drive(1'b0);
      fr = rand_frame();
      send_frame(fr, (n % 4) != 0, 1'b1, 1'b0, "R3");
      chk(frame_err_o == 1'b0, "R7", "no error on clean frame", {63'd0, frame_err_o}, 64'd0);
    end

    // abort mid-frame
    drive(1'b0);
    held  = incr_o;
    fr    = rand_frame();
    early = 0;
    drive(1'b1);
    drive(1'b1);
    for (int i = 0; i < 30; i++) begin
      drive(fr[i]);
      drive(fr[i]);
    end
    mode_en = 1'b0;
    drive(1'b0);
    repeat (3) drive(1'b0);
    chk(frame_err_o == 1'b1, "R7", "error after abort", {63'd0, frame_err_o}, 64'd1);
    chk(early == 0, "R7", "no strobe for aborted frame", early, 64'd0);
    chk(incr_o == held, "R6", "held after abort", {42'd0, incr_o}, {42'd0, held});

    // mode off: frame ignored, error flag kept
    send_frame(rand_frame(), 1'b0, 1'b0, 1'b0, "R8");
    chk(frame_err_o == 1'b1, "R7", "error kept while off", {63'd0, frame_err_o}, 64'd1);
    repeat (3) drive(1'b0);
    mode_en = 1'b1;
    drive(1'b0);
    fr = rand_frame();
    send_frame(fr, 1'b1, 1'b1, 1'b0, "R7");
    chk(frame_err_o == 1'b0, "R7", "error cleared by good frame", {63'd0, frame_err_o}, 64'd0);

    // line left high after a frame: no new frame
    drive(1'b0);
    fr     = rand_frame();
    fr[66] = 1'b1;
    send_frame(fr, 1'b0, 1'b1, 1'b1, "R4");
    held  = incr_o;
    early = 0;
    repeat (300) drive(1'b1);
    chk(early == 0, "R9", "no frame while line stays high", early, 64'd0);
    chk(incr_o == held, "R9", "increment kept", {42'd0, incr_o}, {42'd0, held});
    drive(1'b0);
    fr = rand_frame();
    send_frame(fr, 1'b1, 1'b1, 1'b0, "R9");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule